// File: doc/BRIEF.md
# Timer Channel Readout and Capture Logic

This block serves the CPU-facing read side of a three-channel interval timer. Each channel keeps a 16-bit count snapshot and an 8-bit status snapshot. While nothing is frozen, a read of a channel port returns bytes of the live count supplied by the counting logic. Commands written to the shared control port can freeze the count of one channel, or the count and/or status of several channels at once. Each channel releases its own snapshot once the CPU has read it.

Reads are served in the byte order that the channel's stored access format selects. A frozen status byte is always returned before a frozen count. A control word that reprograms a channel discards that channel's snapshots and restarts its byte order. The counting element, the storage of the control bits and the output pin logic sit outside this block. They supply their state through input ports.

Top module: `tmr_readout`

## Requirements
- R1: A control-port write with bits 5:4 = 00 is a count-freeze command for the channel numbered by bits 7:6 (0, 1 or 2). On the clock edge that accepts it, that channel's snapshot takes the live count, and later reads of the channel return the snapshot instead of the live value.
- R2: A frozen count stays held until its last byte has been read. It is also released by a control word that reprograms the channel: bits 7:6 give the channel and bits 5:4 are not 00. A reprogram also drops a frozen status and sets the byte order back to the low byte. After a release, reads follow the live count again.
- R3: A count-freeze request, of either kind, made to a channel whose count is already frozen and not yet fully read is ignored. The first snapshot is kept.
- R4: A write with bits 7:6 = 11 is a multi-channel capture command. Bit 5 = 0 requests a count freeze and bit 4 = 0 requests a status freeze. Bits 3, 2 and 1 select channels 2, 1 and 0, and any combination may be set. Bit 0 has no effect.
- R5: Reading one channel never releases the snapshot of another channel.
- R6: When a channel has both status and count frozen, the first read returns the status byte. The following one or two reads, depending on the access format, return the frozen count.
- R7: A status-freeze request to a channel whose status is already frozen and unread is ignored, so the first captured status is kept.
- R8: The status byte is {output level, null-count flag, stored control bits 5:0}, with the output level in bit 7.
- R9: The access format is the stored control bits 5:4. 01 returns the low byte only and 10 returns the high byte only. 11 alternates low byte then high byte, and the toggle advances only on count reads. 00 is treated as low only. A count read completes on the single read in formats 01, 10 and 00, and on the high-byte read in format 11.
- R10: Read data is combinational in the cycle of the read strobe and is zero when no strobe is active. If several strobes are active, the lowest-numbered channel supplies the data, and every strobed channel advances its read state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Control-port write strobe, one cycle per byte |
| cmd_data | input | 8 | Control-port byte |
| live_count | input | 48 | Live counts, channel n in bits 16n+15:16n |
| out_level | input | 3 | Output pin level per channel |
| null_cnt | input | 3 | Null-count flag per channel |
| ctrl_bits | input | 18 | Stored control bits 5:0 per channel, channel n in bits 6n+5:6n |
| rd_stb | input | 3 | Read strobe per channel port |
| rd_data | output | 8 | Read data byte |

## Verification
The bound checker checks on every cycle several properties per channel. A freeze captures the live count, and a repeated count or status freeze leaves the snapshot untouched. A reprogram drops both snapshots, and a capture command latches the selected channels. A frozen status wins the data bus, and the bus is zero when nothing is read. The byte order across consecutive reads, the release only after the last byte, the independence of channels and the priority among several strobes depend on sequences of reads. Only the bench's scenarios show these, and the bench compares them against its behavioural model on every clock.

// File: rtl/tmr_readout_pkg.sv
package tmr_readout_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int CTL_W  = 6;

  typedef enum logic [1:0] {
    FMT_NONE = 2'b00,
    FMT_LO   = 2'b01,
    FMT_HI   = 2'b10,
    FMT_LOHI = 2'b11
  } acc_fmt_e;

  typedef struct packed {
    logic cnt;   // freeze count
    logic st;    // freeze status
    logic prog;  // channel reprogrammed
  } chan_req_t;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmr_readout_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                  cmd_we,
  input  logic [BYTE_W-1:0]     cmd_data,
  output chan_req_t [NCH-1:0]   req_o
);
  logic multi_cap;
  assign multi_cap = (cmd_data[7:6] == 2'b11);

  always_comb begin
    req_o = '0;
    if (cmd_we) begin
      for (int i = 0; i < NCH; i++) begin
        if (multi_cap) begin
          // select bits 1..NCH map to channels 0..NCH-1, bit 0 unused
          if (cmd_data[i+1]) begin
            req_o[i].cnt = ~cmd_data[5];
            req_o[i].st  = ~cmd_data[4];
          end
        end else if (cmd_data[7:6] == 2'(i)) begin
          if (cmd_data[5:4] == 2'b00) req_o[i].cnt  = 1'b1;
          else                        req_o[i].prog = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_chan_readout.sv
module tmr_chan_readout
  import tmr_readout_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  chan_req_t         req_i,
  input  logic              rd_stb_i,
  input  logic [CNT_W-1:0]  live_i,
  input  logic              out_level_i,
  input  logic              null_cnt_i,
  input  logic [CTL_W-1:0]  ctrl_i,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic              cnt_lat_o,
  output logic              st_lat_o,
  output logic [CNT_W-1:0]  cnt_hold_o,
  output logic [BYTE_W-1:0] st_hold_o
);
  logic              cnt_lat_q, cnt_lat_d;
  logic              st_lat_q,  st_lat_d;
  logic              hi_nxt_q,  hi_nxt_d;
  logic [CNT_W-1:0]  cnt_hold_q, cnt_hold_d;
  logic [BYTE_W-1:0] st_hold_q,  st_hold_d;
  logic              upd_en;

  acc_fmt_e          fmt;
  logic [CNT_W-1:0]  src;
  logic              hi_sel, cnt_read, last_byte;

  assign fmt       = acc_fmt_e'(ctrl_i[5:4]);
  assign src       = cnt_lat_q ? cnt_hold_q : live_i;
  assign hi_sel    = (fmt == FMT_HI) || ((fmt == FMT_LOHI) && hi_nxt_q);
  assign cnt_read  = rd_stb_i && !st_lat_q;
  assign last_byte = cnt_read && ((fmt != FMT_LOHI) || hi_nxt_q);
  assign upd_en    = rd_stb_i || req_i.cnt || req_i.st || req_i.prog;

  always_comb begin
    if (!rd_stb_i)     rd_byte_o = '0;
    else if (st_lat_q) rd_byte_o = st_hold_q;
    else if (hi_sel)   rd_byte_o = src[CNT_W-1:BYTE_W];
    else               rd_byte_o = src[BYTE_W-1:0];
  end

  always_comb begin
    cnt_lat_d  = cnt_lat_q;
    st_lat_d   = st_lat_q;
    hi_nxt_d   = hi_nxt_q;
    cnt_hold_d = cnt_hold_q;
    st_hold_d  = st_hold_q;
    if (req_i.prog) begin
      cnt_lat_d = 1'b0;
      st_lat_d  = 1'b0;
      hi_nxt_d  = 1'b0;
    end else begin
      if (rd_stb_i && st_lat_q)               st_lat_d  = 1'b0;
      if (cnt_read && (fmt == FMT_LOHI))      hi_nxt_d  = ~hi_nxt_q;
      if (last_byte)                          cnt_lat_d = 1'b0;
      if (req_i.cnt && !cnt_lat_q) begin
        cnt_lat_d  = 1'b1;
        cnt_hold_d = live_i;
      end
      if (req_i.st && !st_lat_q) begin
        st_lat_d  = 1'b1;
        st_hold_d = {out_level_i, null_cnt_i, ctrl_i};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lat_q  <= 1'b0;
      st_lat_q   <= 1'b0;
      hi_nxt_q   <= 1'b0;
      cnt_hold_q <= '0;
      st_hold_q  <= '0;
    end else if (upd_en) begin
      cnt_lat_q  <= cnt_lat_d;
      st_lat_q   <= st_lat_d;
      hi_nxt_q   <= hi_nxt_d;
      cnt_hold_q <= cnt_hold_d;
      st_hold_q  <= st_hold_d;
    end
  end

  assign cnt_lat_o  = cnt_lat_q;
  assign st_lat_o   = st_lat_q;
  assign cnt_hold_o = cnt_hold_q;
  assign st_hold_o  = st_hold_q;
endmodule

// File: rtl/tmr_readout.sv
module tmr_readout
  import tmr_readout_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_we,
  input  logic [BYTE_W-1:0]       cmd_data,
  input  logic [NCH*CNT_W-1:0]    live_count,
  input  logic [NCH-1:0]          out_level,
  input  logic [NCH-1:0]          null_cnt,
  input  logic [NCH*CTL_W-1:0]    ctrl_bits,
  input  logic [NCH-1:0]          rd_stb,
  output logic [BYTE_W-1:0]       rd_data
);
  chan_req_t [NCH-1:0]       req;
  logic [NCH-1:0]            cnt_lat_v, st_lat_v;
  logic [NCH*CNT_W-1:0]      cnt_hold_v;
  logic [NCH*BYTE_W-1:0]     st_hold_v;
  logic [BYTE_W-1:0]         byte_v [NCH];

  tmr_cmd_decode #(.NCH(NCH)) u_dec (
    .cmd_we   (cmd_we),
    .cmd_data (cmd_data),
    .req_o    (req)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_chan_readout u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req[g]),
      .rd_stb_i    (rd_stb[g]),
      .live_i      (live_count[g*CNT_W +: CNT_W]),
      .out_level_i (out_level[g]),
      .null_cnt_i  (null_cnt[g]),
      .ctrl_i      (ctrl_bits[g*CTL_W +: CTL_W]),
      .rd_byte_o   (byte_v[g]),
      .cnt_lat_o   (cnt_lat_v[g]),
      .st_lat_o    (st_lat_v[g]),
      .cnt_hold_o  (cnt_hold_v[g*CNT_W +: CNT_W]),
      .st_hold_o   (st_hold_v[g*BYTE_W +: BYTE_W])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (rd_stb[i]) rd_data = byte_v[i];
    end
  end
endmodule

// File: rtl/tmr_readout_chk.sv
module tmr_readout_chk #(
  parameter int NCH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_we,
  input logic [7:0]        cmd_data,
  input logic [NCH*16-1:0] live_count,
  input logic [NCH-1:0]    rd_stb,
  input logic [7:0]        rd_data,
  input logic [NCH-1:0]    cnt_lat_v,
  input logic [NCH-1:0]    st_lat_v,
  input logic [NCH*16-1:0] cnt_hold_v,
  input logic [NCH*8-1:0]  st_hold_v
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    logic frz_cmd, prog_cmd, rb_cnt;
    assign frz_cmd  = cmd_we && (cmd_data[7:6] == 2'(g)) && (cmd_data[5:4] == 2'b00);
    assign prog_cmd = cmd_we && (cmd_data[7:6] == 2'(g)) && (cmd_data[5:4] != 2'b00);
    assign rb_cnt   = cmd_we && (cmd_data[7:6] == 2'b11) && !cmd_data[5] && cmd_data[g+1];

    assert_freeze_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_cmd && !cnt_lat_v[g]) |=>
        (cnt_lat_v[g] && cnt_hold_v[g*16 +: 16] == $past(live_count[g*16 +: 16])));

    assert_reprog_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      prog_cmd |=> (!cnt_lat_v[g] && !st_lat_v[g]));

    assert_second_freeze_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_lat_v[g] && (frz_cmd || rb_cnt) && !rd_stb[g]) |=>
        (cnt_lat_v[g] && $stable(cnt_hold_v[g*16 +: 16])));

    assert_capture_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_cnt && !cnt_lat_v[g]) |=> cnt_lat_v[g]);

    assert_status_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_lat_v[g] && rd_stb == NCH'(1 << g)) |-> (rd_data == st_hold_v[g*8 +: 8]));

    assert_status_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_lat_v[g] && !rd_stb[g] && !prog_cmd) |=>
        (st_lat_v[g] && $stable(st_hold_v[g*8 +: 8])));
  end

  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb == '0) |-> (rd_data == 8'h00));
endmodule

bind tmr_readout tmr_readout_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_we     (cmd_we),
  .cmd_data   (cmd_data),
  .live_count (live_count),
  .rd_stb     (rd_stb),
  .rd_data    (rd_data),
  .cnt_lat_v  (cnt_lat_v),
  .st_lat_v   (st_lat_v),
  .cnt_hold_v (cnt_hold_v),
  .st_hold_v  (st_hold_v)
);

// File: tb/tmr_readout_test.sv
module tmr_readout_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_we;
  logic [7:0]  cmd;
  logic [15:0] live [3];
  logic [5:0]  ctrl [3];
  logic [2:0]  outl, nul, rd;
  logic [47:0] live_bus;
  logic [17:0] ctrl_bus;
  logic [7:0]  rd_data;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R10";
  bit    done = 0;

  // behavioural reference state
  bit m_cl [3];
  bit m_sl [3];
  bit m_hi [3];
  int m_ch [3];
  int m_sh [3];

  always #5 clk = ~clk;

  assign live_bus = {live[2], live[1], live[0]};
  assign ctrl_bus = {ctrl[2], ctrl[1], ctrl[0]};

  tmr_readout uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .cmd_data   (cmd),
    .live_count (live_bus),
    .out_level  (outl),
    .null_cnt   (nul),
    .ctrl_bits  (ctrl_bus),
    .rd_stb     (rd),
    .rd_data    (rd_data)
  );

  // live counts move every cycle so a frozen value is distinguishable
  always @(negedge clk) begin
    for (int c = 0; c < 3; c++) live[c] <= live[c] - 16'(c + 1) * 16'h0101;
  end

  function automatic int exp_data();
    int c, src, fmt;
    bit hi;
    if (rd == 3'b000) return 0;
    c = rd[0] ? 0 : (rd[1] ? 1 : 2);
    if (m_sl[c]) return m_sh[c];
    src = m_cl[c] ? m_ch[c] : int'(live[c]);
    fmt = int'(ctrl[c][5:4]);
    hi  = (fmt == 2) || (fmt == 3 && m_hi[c]);
    return hi ? ((src >> 8) & 255) : (src & 255);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        m_cl[c] = 0; m_sl[c] = 0; m_hi[c] = 0; m_ch[c] = 0; m_sh[c] = 0;
      end
    end else begin
      for (int c = 0; c < 3; c++) begin
        bit rb, sel, prog, lc, ls, was_cl, was_sl;
        rb   = cmd_we && cmd[7:6] == 2'b11;
        sel  = rb ? cmd[c+1] : (cmd_we && int'(cmd[7:6]) == c);
        prog = !rb && sel && cmd[5:4] != 2'b00;
        lc   = sel && (rb ? !cmd[5] : cmd[5:4] == 2'b00);
        ls   = rb && sel && !cmd[4];
        if (prog) begin
          m_cl[c] = 0; m_sl[c] = 0; m_hi[c] = 0;
        end else begin
          was_cl = m_cl[c];
          was_sl = m_sl[c];
          if (rd[c]) begin
            if (was_sl) m_sl[c] = 0;
            else if (ctrl[c][5:4] == 2'b11) begin
              if (m_hi[c]) m_cl[c] = 0;
              m_hi[c] = !m_hi[c];
            end else m_cl[c] = 0;
          end
          if (lc && !was_cl) begin m_cl[c] = 1; m_ch[c] = int'(live[c]); end
          if (ls && !was_sl) begin m_sl[c] = 1; m_sh[c] = int'({outl[c], nul[c], ctrl[c]}); end
        end
      end
    end
  end

  // compare on every clock, after inputs driven at the falling edge settle
  always @(negedge clk) begin
    #2;
    if (!done) begin
      checks++;
      if (int'(rd_data) != exp_data()) begin
        errors++;
        $display("FAIL %s rd=%b actual=%02h expected=%02h at %0t",
                 cur_req, rd, rd_data, exp_data(), $time);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_we = 0; rd = 3'b000;
    end
  endtask

  task automatic wr(logic [7:0] b);
    @(negedge clk);
    rd = 3'b000; cmd_we = 1; cmd = b;
    if (b[7:6] != 2'b11 && b[5:4] != 2'b00) ctrl[b[7:6]] = b[5:0];
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic rdp(logic [2:0] s);
    @(negedge clk);
    cmd_we = 0; rd = s;
    @(negedge clk);
    rd = 3'b000;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_we = 0; cmd = 8'h00; rd = 3'b000;
    outl = 3'b101; nul = 3'b010;
    live[0] = 16'h1234; live[1] = 16'hABCD; live[2] = 16'h00FF;
    ctrl[0] = 6'b110100; ctrl[1] = 6'b010100; ctrl[2] = 6'b100110;
    // reset state: bus idle at zero (R10)
    idle(3);
    rst_n = 1;
    idle(2);

    // R9: formats low-then-high, low only, high only on live counts
    cur_req = "R9";
    wr(8'h34); wr(8'h54); wr(8'hA6);
    rdp(3'b001); rdp(3'b001); rdp(3'b010); rdp(3'b100); rdp(3'b001);
    rdp(3'b001);

    // R1 / R2: freeze channel 0, read both bytes, then live again
    cur_req = "R1";
    wr(8'h00); idle(3);
    rdp(3'b001); idle(1); rdp(3'b001);
    cur_req = "R2";
    rdp(3'b001); rdp(3'b001);

    // R3: second freeze on channel 1 ignored
    cur_req = "R3";
    wr(8'h40); idle(2); wr(8'h40); idle(2);
    rdp(3'b010); rdp(3'b010);

    // R4 / R5: capture counts of channels 2 and 0, bit 0 set but unused
    cur_req = "R4";
    wr(8'hDB); idle(2);
    cur_req = "R5";
    rdp(3'b100); idle(2); rdp(3'b100);
    rdp(3'b001); idle(1); rdp(3'b001); rdp(3'b001);
    // R4: bit 0 alone selects nothing
    cur_req = "R4";
    wr(8'hC1); idle(1); rdp(3'b010); rdp(3'b001); rdp(3'b001);

    // R6 / R8: count and status of channel 1, status first
    cur_req = "R6";
    outl = 3'b010; nul = 3'b000;
    wr(8'hC4); idle(2);
    rdp(3'b010); rdp(3'b010); rdp(3'b010);
    cur_req = "R8";
    wr(8'hE8); outl = 3'b011; nul = 3'b100; idle(1); rdp(3'b100);
    rdp(3'b100);

    // R7: repeated status freeze on channel 0 keeps first status
    cur_req = "R7";
    wr(8'hE2); outl = 3'b000; nul = 3'b111; idle(1);
    wr(8'hE2); idle(1);
    rdp(3'b001); rdp(3'b001); rdp(3'b001);

    // R2: reprogram drops snapshots and restarts byte order
    cur_req = "R2";
    wr(8'h80); wr(8'hC8); wr(8'hB4);
    rdp(3'b100); rdp(3'b100);
    rdp(3'b001); wr(8'h36); rdp(3'b001); rdp(3'b001);

    // R10: several strobes, lowest channel drives the bus
    cur_req = "R10";
    wr(8'hCE); idle(1);
    rdp(3'b110); rdp(3'b110); rdp(3'b100); rdp(3'b111); rdp(3'b111);
    idle(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule